// File: doc/BRIEF.md
# Three-State Bus Transmit Serializer

This block turns a stream of bytes into bit-serial line activity for a shared differential bus reached through a transceiver that has a driver-enable pin. Every bit period puts the line in one of three conditions: strong 0 (driver on, data low), strong 1 (driver on, data high) or weak 1 (driver off, so the bus bias holds the line recessive). Bit boundaries come from a one-cycle baud tick supplied from outside, and the block only advances on that tick.

In normal mode a frame can be led by a run of strong-1 bit times, so the transceiver has turned its driver on before the start bit arrives. In arbitration mode several nodes may drive at once, so strong 1 is never produced: ones go out weak and zeros strong, and no lead-in is sent. In break-sync mode an idle-timeout indication makes the block put out a long low break that only marks the bus as busy; it also avoids strong 1, since several nodes may emit it together.

Top module: `tri_bus_tx_ser`

## Requirements
- R1: After reset tx_en is 0, tx_data is 1, busy is 0 and in_ready is 1.
- R2: in_ready equals the inverse of busy; a byte offered while busy is dropped and starts no frame.
- R3: A byte accepted in normal mode (mode 0, or the unused code 3) produces pre_len bit times of strong 1, a strong-0 start bit, the 8 data bits least significant first driven strong (tx_en 1, tx_data equal to the bit), then a strong-1 stop bit; the first bit period begins the cycle after acceptance and each period ends on a baud tick.
- R4: A pre_len of 0 sends no lead-in; the start bit follows acceptance directly.
- R5: In arbitration mode (mode 1) pre_len is ignored, data bits of 1 and the stop bit go out as weak 1, and data bits of 0 and the start bit go out as strong 0.
- R6: In break-sync mode (mode 2), idle_timeout high while idle starts BRK_BITS bit times of strong 0 with no lead-in; it takes priority over a byte offered in the same cycle, which is dropped.
- R7: idle_timeout has no effect in modes 0, 1 and 3, and none while a frame is in progress.
- R8: The cycle after the tick that closes the stop bit or the last break bit, tx_en is 0, tx_data is 1 and busy is 0.
- R9: Whenever tx_en is 0, tx_data is 1.
- R10: mode and pre_len are captured when a byte is accepted; changing them during the frame does not alter it.
- R11: A byte accepted in break-sync mode is framed exactly as in normal mode, lead-in included.
- R12: Between baud ticks the line condition does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse closing each bit period |
| mode | input | 2 | 0 normal, 1 arbitration, 2 break-sync, 3 as normal |
| pre_len | input | PRE_W | Lead-in length in bit times (normal framing only) |
| idle_timeout | input | 1 | Bus has been idle too long (break-sync mode) |
| in_data | input | DATA_BITS | Byte to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | A byte is accepted this cycle if in_valid |
| tx_data | output | 1 | Line data to the transceiver |
| tx_en | output | 1 | Transceiver driver enable |
| busy | output | 1 | A frame or break is in progress |

## Verification
The embedded properties watch, on every cycle, that a disabled driver always pairs with a high data level, that an arbitration frame never drives strong 1, that the sequencer state and captured mode hold between ticks and through a frame, that a break only begins after an idle timeout, and that busy only drops on a tick. Only the bench scenarios can show the exact bit order of each frame, the lead-in length across the full range of pre_len, the break length, priority of a break over a simultaneous byte, and that stray bytes, timeouts and mode changes during a frame leave the line sequence unchanged.

// File: rtl/tri_tx_pkg.sv
package tri_tx_pkg;

   typedef enum logic [1:0] {
      MD_NORM = 2'd0,
      MD_ARB  = 2'd1,
      MD_BRK  = 2'd2,
      MD_RSV  = 2'd3
   } tx_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_START = 3'd2,
      ST_DATA  = 3'd3,
      ST_STOP  = 3'd4,
      ST_BREAK = 3'd5
   } tx_state_e;

   typedef struct packed {
      logic en;
      logic d;
   } line_drive_t;

   localparam line_drive_t DRV_WEAK1   = '{en: 1'b0, d: 1'b1};
   localparam line_drive_t DRV_STRONG1 = '{en: 1'b1, d: 1'b1};
   localparam line_drive_t DRV_STRONG0 = '{en: 1'b1, d: 1'b0};

endpackage

// File: rtl/tri_tx_seq.sv
module tri_tx_seq
   import tri_tx_pkg::*;
#(
   parameter int PRE_W     = 4,
   parameter int DATA_BITS = 8,
   parameter int BRK_BITS  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic [1:0]       mode,
   input  logic [PRE_W-1:0] pre_len,
   input  logic             idle_timeout,
   input  logic             in_valid,
   output tx_state_e        st,
   output tx_mode_e         md,
   output logic             load,
   output logic             step
);

   localparam int CW_D = $clog2(DATA_BITS + 1);
   localparam int CW_B = $clog2(BRK_BITS + 1);
   localparam int CW_X = (CW_D > CW_B) ? CW_D : CW_B;
   localparam int CW   = (CW_X > PRE_W) ? CW_X : PRE_W;

   tx_state_e      st_n;
   tx_mode_e       md_n;
   logic [CW-1:0]  cnt, cnt_n;
   logic           last;

   assign last = (cnt == '0);

   always_comb begin
      st_n  = st;
      md_n  = md;
      cnt_n = cnt;
      load  = 1'b0;
      step  = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (idle_timeout && tx_mode_e'(mode) == MD_BRK) begin
               st_n  = ST_BREAK;
               md_n  = MD_BRK;
               cnt_n = CW'(BRK_BITS - 1);
            end else if (in_valid) begin
               load = 1'b1;
               md_n = tx_mode_e'(mode);
               if (tx_mode_e'(mode) != MD_ARB && pre_len != '0) begin
                  st_n  = ST_PRE;
                  cnt_n = CW'(pre_len) - CW'(1);
               end else begin
                  st_n = ST_START;
               end
            end
         end
         ST_PRE: if (baud_tick) begin
            if (last) st_n = ST_START;
            else      cnt_n = cnt - CW'(1);
         end
         ST_START: if (baud_tick) begin
            st_n  = ST_DATA;
            cnt_n = CW'(DATA_BITS - 1);
         end
         ST_DATA: if (baud_tick) begin
            step = 1'b1;
            if (last) st_n = ST_STOP;
            else      cnt_n = cnt - CW'(1);
         end
         ST_STOP: if (baud_tick) st_n = ST_IDLE;
         ST_BREAK: if (baud_tick) begin
            if (last) st_n = ST_IDLE;
            else      cnt_n = cnt - CW'(1);
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         md  <= MD_NORM;
         cnt <= '0;
      end else begin
         st  <= st_n;
         md  <= md_n;
         cnt <= cnt_n;
      end
   end

   // R12
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && !baud_tick) |=> (st == $past(st)));

   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> (md == $past(md)));

   // R6
   break_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_BREAK) |-> $past(idle_timeout));

endmodule

// File: rtl/tri_tx_shift.sv
module tri_tx_shift #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic [DATA_BITS-1:0] din,
   output logic                 bit_out
);

   logic [DATA_BITS-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr <= '0;
      else if (load) sr <= din;
      else if (step) sr <= sr >> 1;
   end

   assign bit_out = sr[0];

endmodule

// File: rtl/tri_tx_drive.sv
module tri_tx_drive
   import tri_tx_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  tx_state_e st,
   input  tx_mode_e  md,
   input  logic      bit_in,
   output logic      tx_en,
   output logic      tx_data
);

   line_drive_t drv;

   always_comb begin
      unique case (st)
         ST_IDLE:  drv = DRV_WEAK1;
         ST_PRE:   drv = DRV_STRONG1;
         ST_START: drv = DRV_STRONG0;
         ST_DATA:  drv = (md == MD_ARB) ? '{en: ~bit_in, d: bit_in}
                                        : '{en: 1'b1,    d: bit_in};
         ST_STOP:  drv = (md == MD_ARB) ? DRV_WEAK1 : DRV_STRONG1;
         ST_BREAK: drv = DRV_STRONG0;
         default:  drv = DRV_WEAK1;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_en   <= 1'b0;
               tx_data <= 1'b1;
            end else begin
               tx_en   <= drv.en;
               tx_data <= drv.d;
            end
         end
      end else begin : g_comb
         assign tx_en   = drv.en;
         assign tx_data = drv.d;
      end
   endgenerate

   // R9
   weak_is_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> tx_data);

   // R5
   arb_no_strong1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md == MD_ARB && st != ST_IDLE && st != ST_BREAK) |-> !(drv.en && drv.d));

endmodule

// File: rtl/tri_bus_tx_ser.sv
module tri_bus_tx_ser
   import tri_tx_pkg::*;
#(
   parameter int PRE_W     = 4,
   parameter int DATA_BITS = 8,
   parameter int BRK_BITS  = 10,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 baud_tick,
   input  logic [1:0]           mode,
   input  logic [PRE_W-1:0]     pre_len,
   input  logic                 idle_timeout,
   input  logic [DATA_BITS-1:0] in_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   output logic                 tx_data,
   output logic                 tx_en,
   output logic                 busy
);

   generate
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre
         $error("PRE_W out of range");
      end
      if (DATA_BITS < 1) begin : g_bad_data
         $error("DATA_BITS must be positive");
      end
      if (BRK_BITS < 1) begin : g_bad_brk
         $error("BRK_BITS must be positive");
      end
   endgenerate

   tx_state_e st;
   tx_mode_e  md;
   logic      load, step, bit_cur;

   tri_tx_seq #(
      .PRE_W(PRE_W), .DATA_BITS(DATA_BITS), .BRK_BITS(BRK_BITS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
      .pre_len(pre_len), .idle_timeout(idle_timeout), .in_valid(in_valid),
      .st(st), .md(md), .load(load), .step(step)
   );

   tri_tx_shift #(.DATA_BITS(DATA_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .din(in_data), .bit_out(bit_cur)
   );

   tri_tx_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk(clk), .rst_n(rst_n), .st(st), .md(md), .bit_in(bit_cur),
      .tx_en(tx_en), .tx_data(tx_data)
   );

   assign busy     = (st != ST_IDLE);
   assign in_ready = ~busy;

   // R8
   release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(baud_tick));

endmodule

// File: tb/sim_tri_bus_tx_ser.sv
`timescale 1ns/1ps
module sim_tri_bus_tx_ser;

   localparam int PW  = 3;
   localparam int BRK = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          baud_tick = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [PW-1:0] pre_len = '0;
   logic          idle_timeout = 1'b0;
   logic [7:0]    in_data = 8'h00;
   logic          in_valid = 1'b0;
   logic          in_ready, tx_data, tx_en, busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tri_bus_tx_ser #(.PRE_W(PW), .DATA_BITS(8), .BRK_BITS(BRK)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
      .pre_len(pre_len), .idle_timeout(idle_timeout), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .tx_data(tx_data),
      .tx_en(tx_en), .busy(busy)
   );

   task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick_once();
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
   endtask

   task automatic check_idle(string tag);
      chk(tag, {tx_en, tx_data, busy, in_ready}, 4'b0101);
   endtask

   // Sends one byte and checks every bit period (R3 R4 R5 R10 R11 R12).
   task automatic send_frame(input logic [1:0] md, input int pre,
                             input logic [7:0] b, input int gap,
                             input bit disturb);
      logic [1:0] exp_bits [0:31];
      int n;
      n = 0;
      if (md != 2'd1 && pre != 0)
         for (int i = 0; i < pre; i++) begin exp_bits[n] = 2'b11; n++; end
      exp_bits[n] = 2'b10; n++;
      for (int i = 0; i < 8; i++) begin
         if (md == 2'd1) exp_bits[n] = b[i] ? 2'b01 : 2'b10;
         else            exp_bits[n] = {1'b1, b[i]};
         n++;
      end
      exp_bits[n] = (md == 2'd1) ? 2'b01 : 2'b11; n++;

      mode = md; pre_len = PW'(pre); in_data = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         if (disturb && k == 3) begin
            chk("R2 ready low while busy", {3'b0, in_ready}, 4'b0000);
            mode = ~md; pre_len = ~pre_len; in_data = ~b;
            in_valid = 1'b1; idle_timeout = 1'b1;
         end
         if (disturb && k == 4) begin
            in_valid = 1'b0; idle_timeout = 1'b0;
         end
         chk("R3/R5 bit drive", {2'b00, tx_en, tx_data}, {2'b00, exp_bits[k]});
         chk("R3 busy in frame", {3'b0, busy}, 4'b0001);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk("R12 hold between ticks", {2'b00, tx_en, tx_data},
                {2'b00, exp_bits[k]});
         end
         tick_once();
      end
      check_idle("R8 released after stop");
      mode = md;
   endtask

   initial begin
      logic [7:0] pats [0:5];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
      pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

      repeat (3) @(negedge clk);
      check_idle("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset release");

      // R3 R4: normal mode across every lead-in length
      for (int p = 0; p < (1 << PW); p++)
         for (int j = 0; j < 6; j++)
            send_frame(2'd0, p, pats[j], 0, 1'b0);

      // R3: unused mode code behaves as normal, with spaced ticks (R12)
      send_frame(2'd3, 2, 8'h3C, 2, 1'b0);

      // R5: arbitration ignores lead-in
      for (int j = 0; j < 6; j++)
         send_frame(2'd1, 5, pats[j], 1, 1'b0);

      // R11: byte in break-sync mode framed as normal
      send_frame(2'd2, 3, 8'hC3, 0, 1'b0);

      // R2 R7 R10: stray byte, timeout and mode change during frames
      send_frame(2'd0, 2, 8'h96, 0, 1'b1);
      send_frame(2'd1, 0, 8'h69, 0, 1'b1);
      send_frame(2'd2, 1, 8'h0F, 0, 1'b1);
      @(negedge clk);
      check_idle("R2 dropped byte started nothing");

      // R7: timeout ignored outside break-sync mode
      for (int m = 0; m < 4; m++) begin
         if (m != 2) begin
            mode = 2'(m); idle_timeout = 1'b1;
            @(negedge clk);
            idle_timeout = 1'b0;
            check_idle("R7 timeout ignored");
            @(negedge clk);
            check_idle("R7 timeout ignored later");
         end
      end

      // R6: break wins over a byte offered in the same cycle
      mode = 2'd2; pre_len = 3'd4; idle_timeout = 1'b1;
      in_valid = 1'b1; in_data = 8'hFF;
      @(negedge clk);
      idle_timeout = 1'b0; in_valid = 1'b0;
      for (int k = 0; k < BRK; k++) begin
         chk("R6 break bit strong 0", {1'b0, tx_en, tx_data, busy}, 4'b0101);
         tick_once();
      end
      check_idle("R8 released after break");
      @(negedge clk);
      check_idle("R6 simultaneous byte dropped");

      // R6: plain break then a normal byte still works
      idle_timeout = 1'b1;
      @(negedge clk);
      idle_timeout = 1'b0;
      for (int k = 0; k < BRK; k++) begin
         chk("R6 break bit", {1'b0, tx_en, tx_data, busy}, 4'b0101);
         tick_once();
      end
      check_idle("R8 idle after second break");
      send_frame(2'd0, 1, 8'h42, 0, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule